// File: doc/BRIEF.md
# Configuration Bitstream Header Analyser

This block watches an FPGA configuration bitstream as it passes by, one byte per cycle in which `in_valid` is high, and works out which kind of load the stream will perform. It locates the synchronization word and then walks the packet headers that follow it, one word at a time and aligned to that word. From the first packet header that carries a frame-data length it takes the payload length. It compares that length with a full-device payload size supplied on an input and labels the stream unknown, full or partial. The block only observes the stream. It neither stores nor forwards any byte, so it can sit beside the path that feeds the device.

`family_wide` selects the word handling. When it is 1, words are 32 bits and the header layout is the wide one. When it is 0, words are 16 bits and the length follows a 16-bit type-2 header. The byte that carries `in_last` closes the stream. On the next cycle the block raises `done_o` for one cycle and presents the mode, the payload size in bytes and the sync offset. These results hold until the next stream closes.

The control is one state machine. `ST_HUNT` looks for the sync word, and a match moves it to `ST_SCAN`. From `ST_SCAN`, a wide type-1 frame-data write header goes to `ST_HOLD` if its count is nonzero and to `ST_T2_NEXT` if its count is zero. A narrow type-2 header goes to `ST_LEN_HI`. `ST_T2_NEXT` goes to `ST_HOLD` on a type-2 word; on any other word it treats that word as a fresh `ST_SCAN` candidate. `ST_LEN_HI` moves to `ST_LEN_LO`, and `ST_LEN_LO` moves to `ST_HOLD`. `ST_HOLD` stays put until the stream ends. The end of a stream returns every state to `ST_HUNT`.

Top module: `bitstream_mode_detect`

## Requirements
- R1: With `family_wide`=1 the sync word is the byte run 0xAA,0x99,0x55,0x66. `sync_offset_o` reports the zero-based stream index of its first byte, counting only bytes with `in_valid` high.
- R2: With `family_wide`=0 only the two bytes 0xAA,0x99 form the sync word. With `family_wide`=1 those two bytes alone are not a sync word.
- R3: Header words are assembled big-endian from the bytes just after the sync word, 4 bytes per word (wide) or 2 bytes per word (narrow). A header that straddles this alignment is not recognised.
- R4: Wide family: a word with type bits [31:29]=1, opcode [28:27]=2 and register address [17:13]=2 is a frame-data write header. If its count [10:0] is nonzero, the payload is that count times 4 bytes.
- R5: Wide family: if that header's count is zero and the next word has type bits [31:29]=2, the payload is that word's count [26:0] times 4 bytes.
- R6: Wide family: if the word after a zero-count frame-data header is not type 2, that same word is examined again as a header candidate.
- R7: Narrow family: a 16-bit word with type bits [15:13]=2 is followed by a 32-bit big-endian word count in the next two words. The payload is that count times 2 bytes, truncated to the output width.
- R8: If no sync word was seen by stream end, `mode_o`=0 (unknown) and `payload_bytes_o`=0 and `sync_offset_o`=0.
- R9: If a sync word was seen but no complete length header was found, or the count found is zero, `mode_o`=1 (full) and `payload_bytes_o`=0.
- R10: A nonzero payload equal to `full_size_bytes` gives `mode_o`=1 (full); any other nonzero payload gives `mode_o`=2 (partial).
- R11: `done_o` is high for exactly the one cycle after the `in_last` byte. Results change only then and hold until the next stream end, and the next byte starts a new stream at index 0.
- R12: Only the first length header after the sync word counts; later headers in the same stream are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| family_wide | input | 1 | 1: 32-bit words, 0: 16-bit words |
| full_size_bytes | input | SIZE_W | Payload size of a full-device load, in bytes |
| in_valid | input | 1 | `in_byte` carries a stream byte this cycle |
| in_byte | input | 8 | Stream byte |
| in_last | input | 1 | With `in_valid`, this byte ends the stream |
| mode_o | output | 2 | 0 unknown, 1 full, 2 partial |
| payload_bytes_o | output | SIZE_W | Payload length in bytes (0 if none) |
| sync_offset_o | output | OFF_W | Index of the first sync byte |
| done_o | output | 1 | One-cycle strobe after stream end |

## Verification
The assertions assume that `family_wide` and `full_size_bytes` stay constant from the first byte of a stream until the cycle `done_o` is seen. They also assume that `in_last` is only meaningful together with `in_valid`. The bench drives both settings before the first byte of each stream and changes them only after it has sampled `done_o`. It asserts `in_last` only on a valid byte. Stream lengths stay far below the range of the byte-index counter, so the sync offset never wraps. Random idle cycles are inserted between valid bytes so that alignment is shown to depend on valid bytes only.

// File: rtl/bsc_pkg.sv
package bsc_pkg;

    localparam logic [31:0] SYNC_PATTERN = 32'hAA99_5566;
    localparam logic [2:0]  PKT_T1       = 3'd1;
    localparam logic [2:0]  PKT_T2       = 3'd2;
    localparam logic [1:0]  OPC_WRITE    = 2'd2;
    localparam logic [4:0]  REG_FRAME_IN = 5'd2;

    typedef enum logic [1:0] {
        CLS_UNKNOWN = 2'd0,
        CLS_FULL    = 2'd1,
        CLS_PARTIAL = 2'd2
    } cls_e;

    typedef enum logic [2:0] {
        ST_HUNT    = 3'd0,
        ST_SCAN    = 3'd1,
        ST_T2_NEXT = 3'd2,
        ST_LEN_HI  = 3'd3,
        ST_LEN_LO  = 3'd4,
        ST_HOLD    = 3'd5
    } scan_st_e;

    typedef struct packed {
        logic        t1_frame;
        logic [10:0] t1_count;
        logic        is_t2;
        logic [26:0] t2_count;
    } hdr_info_t;

endpackage

// File: rtl/bsc_sync_match.sv
module bsc_sync_match
    import bsc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       enable,
    input  logic       wide,
    input  logic       in_valid,
    input  logic [7:0] in_byte,
    output logic       hit
);

    logic [23:0] hist_q;
    logic [31:0] window;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (clear) begin
            hist_q <= '0;
        end else if (in_valid) begin
            hist_q <= {hist_q[15:0], in_byte};
        end
    end

    always_comb begin
        window = {hist_q, in_byte};
        if (wide) begin
            hit = in_valid && enable && (window == SYNC_PATTERN);
        end else begin
            hit = in_valid && enable && (window[15:0] == SYNC_PATTERN[31:16]);
        end
    end

endmodule

// File: rtl/bsc_word_pack.sv
module bsc_word_pack (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        active,
    input  logic        wide,
    input  logic        in_valid,
    input  logic [7:0]  in_byte,
    output logic        word_vld,
    output logic [31:0] word
);

    logic [23:0] sh_q;
    logic [1:0]  phase_q;
    logic [1:0]  last_phase;

    assign last_phase = wide ? 2'd3 : 2'd1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh_q    <= '0;
            phase_q <= '0;
        end else begin
            if (in_valid) begin
                sh_q <= {sh_q[15:0], in_byte};
            end
            if (!active) begin
                phase_q <= '0;
            end else if (in_valid) begin
                phase_q <= (phase_q == last_phase) ? 2'd0 : phase_q + 2'd1;
            end
        end
    end

    always_comb begin
        word_vld = active && in_valid && (phase_q == last_phase);
        if (wide) begin
            word = {sh_q, in_byte};
        end else begin
            word = {16'h0000, sh_q[7:0], in_byte};
        end
    end

    // R3: a narrow stream never reaches the upper byte phases
    p_phase_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!wide && active) |-> (phase_q <= 2'd1));

endmodule

// File: rtl/bsc_hdr_decode.sv
module bsc_hdr_decode
    import bsc_pkg::*;
(
    input  logic        wide,
    input  logic [31:0] word,
    output hdr_info_t   info
);

    always_comb begin
        info.t1_frame = wide
                     && (word[31:29] == PKT_T1)
                     && (word[28:27] == OPC_WRITE)
                     && (word[17:13] == REG_FRAME_IN);
        info.t1_count = word[10:0];
        info.is_t2    = wide ? (word[31:29] == PKT_T2) : (word[15:13] == PKT_T2);
        info.t2_count = word[26:0];
    end

endmodule

// File: rtl/bitstream_mode_detect.sv
module bitstream_mode_detect
    import bsc_pkg::*;
#(
    parameter int SIZE_W = 32,
    parameter int OFF_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              family_wide,
    input  logic [SIZE_W-1:0] full_size_bytes,
    input  logic              in_valid,
    input  logic [7:0]        in_byte,
    input  logic              in_last,
    output logic [1:0]        mode_o,
    output logic [SIZE_W-1:0] payload_bytes_o,
    output logic [OFF_W-1:0]  sync_offset_o,
    output logic              done_o
);

    localparam logic [OFF_W-1:0] BACK_WIDE   = OFF_W'(3);
    localparam logic [OFF_W-1:0] BACK_NARROW = OFF_W'(1);

    scan_st_e          st_q, st_nx, scan_st;
    logic [OFF_W-1:0]  pos_q, off_q, off_nx;
    logic [SIZE_W-1:0] cnt_q, cnt_nx, scan_cnt, bytes_fin;
    logic [15:0]       hi_q, hi_nx;
    logic              stream_end, sync_hit, word_vld;
    logic [31:0]       word;
    hdr_info_t         info;

    cls_e              fin_mode, mode_q;
    logic [SIZE_W-1:0] fin_bytes, bytes_q;
    logic [OFF_W-1:0]  fin_off, offo_q;
    logic              done_q;

    assign stream_end = in_valid && in_last;

    bsc_sync_match u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (stream_end),
        .enable   (st_q == ST_HUNT),
        .wide     (family_wide),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .hit      (sync_hit)
    );

    bsc_word_pack u_pack (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (st_q != ST_HUNT),
        .wide     (family_wide),
        .in_valid (in_valid),
        .in_byte  (in_byte),
        .word_vld (word_vld),
        .word     (word)
    );

    bsc_hdr_decode u_dec (
        .wide (family_wide),
        .word (word),
        .info (info)
    );

    // Outcome of treating the current word as a fresh header candidate
    always_comb begin
        scan_st  = ST_SCAN;
        scan_cnt = cnt_q;
        if (family_wide) begin
            if (info.t1_frame) begin
                if (info.t1_count != 11'd0) begin
                    scan_st  = ST_HOLD;
                    scan_cnt = SIZE_W'(info.t1_count);
                end else begin
                    scan_st = ST_T2_NEXT;
                end
            end
        end else if (info.is_t2) begin
            scan_st = ST_LEN_HI;
        end
    end

    // Next-state logic
    always_comb begin
        st_nx  = st_q;
        cnt_nx = cnt_q;
        off_nx = off_q;
        hi_nx  = hi_q;
        unique case (st_q)
            ST_HUNT: begin
                if (sync_hit) begin
                    st_nx  = ST_SCAN;
                    off_nx = pos_q - (family_wide ? BACK_WIDE : BACK_NARROW);
                end
            end
            ST_SCAN: begin
                if (word_vld) begin
                    st_nx  = scan_st;
                    cnt_nx = scan_cnt;
                end
            end
            ST_T2_NEXT: begin
                if (word_vld) begin
                    if (info.is_t2) begin
                        st_nx  = ST_HOLD;
                        cnt_nx = SIZE_W'(info.t2_count);
                    end else begin
                        st_nx  = scan_st;
                        cnt_nx = scan_cnt;
                    end
                end
            end
            ST_LEN_HI: begin
                if (word_vld) begin
                    hi_nx = word[15:0];
                    st_nx = ST_LEN_LO;
                end
            end
            ST_LEN_LO: begin
                if (word_vld) begin
                    cnt_nx = SIZE_W'({hi_q, word[15:0]});
                    st_nx  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                st_nx = ST_HOLD;
            end
            default: begin
                st_nx = ST_HUNT;
            end
        endcase
    end

    // Classification of the stream as it stands after the current byte
    always_comb begin
        bytes_fin = family_wide ? (cnt_nx << 2) : (cnt_nx << 1);
        if (st_nx == ST_HUNT) begin
            fin_mode  = CLS_UNKNOWN;
            fin_bytes = '0;
            fin_off   = '0;
        end else if ((st_nx == ST_HOLD) && (bytes_fin != '0)) begin
            fin_mode  = (bytes_fin == full_size_bytes) ? CLS_FULL : CLS_PARTIAL;
            fin_bytes = bytes_fin;
            fin_off   = off_nx;
        end else begin
            fin_mode  = CLS_FULL;
            fin_bytes = '0;
            fin_off   = off_nx;
        end
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_HUNT;
            pos_q <= '0;
            off_q <= '0;
            cnt_q <= '0;
            hi_q  <= '0;
        end else if (stream_end) begin
            st_q  <= ST_HUNT;
            pos_q <= '0;
            off_q <= '0;
            cnt_q <= '0;
            hi_q  <= '0;
        end else begin
            st_q  <= st_nx;
            off_q <= off_nx;
            cnt_q <= cnt_nx;
            hi_q  <= hi_nx;
            if (in_valid) begin
                pos_q <= pos_q + OFF_W'(1);
            end
        end
    end

    // Output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q  <= CLS_UNKNOWN;
            bytes_q <= '0;
            offo_q  <= '0;
            done_q  <= 1'b0;
        end else begin
            done_q <= stream_end;
            if (stream_end) begin
                mode_q  <= fin_mode;
                bytes_q <= fin_bytes;
                offo_q  <= fin_off;
            end
        end
    end

    assign mode_o          = mode_q;
    assign payload_bytes_o = bytes_q;
    assign sync_offset_o   = offo_q;
    assign done_o          = done_q;

    // R1: leaving the hunt state requires a sync match on the previous byte
    p_enter_scan_r1: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q != ST_HUNT) && ($past(st_q) == ST_HUNT)) |-> $past(sync_hit));

    // R8: an unknown result carries no size and no offset
    p_unknown_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (mode_o == CLS_UNKNOWN)) |-> ((payload_bytes_o == '0) && (sync_offset_o == '0)));

    // R10: a partial result has a nonzero size different from the full size
    p_partial_size_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (mode_o == CLS_PARTIAL)) |-> ((payload_bytes_o != full_size_bytes) && (payload_bytes_o != '0)));

    // R11: the strobe only follows a stream end
    p_done_after_end_r11: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(stream_end));

    // R11: results hold unless a stream ends
    p_result_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !stream_end |=> ($stable(mode_o) && $stable(payload_bytes_o) && $stable(sync_offset_o)));

    // R12: once a length is captured it stays until the stream ends
    p_first_header_r12: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_HOLD) && !stream_end) |=> ((st_q == ST_HOLD) && $stable(cnt_q)));

endmodule

// File: tb/bitstream_mode_detect_tb_top.sv
module bitstream_mode_detect_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        family_wide;
    logic [31:0] full_size_bytes;
    logic        in_valid;
    logic [7:0]  in_byte;
    logic        in_last;
    logic [1:0]  mode_o;
    logic [31:0] payload_bytes_o;
    logic [15:0] sync_offset_o;
    logic        done_o;

    int checks = 0;
    int errors = 0;
    logic [7:0]  mem [0:255];
    logic [1:0]  prev_mode  = 2'd0;
    logic [31:0] prev_bytes = 32'd0;
    logic [15:0] prev_off   = 16'd0;

    always #4 clk = ~clk;

    bitstream_mode_detect #(.SIZE_W(32), .OFF_W(16)) dut_i (
        .clk             (clk),
        .rst_n           (rst_n),
        .family_wide     (family_wide),
        .full_size_bytes (full_size_bytes),
        .in_valid        (in_valid),
        .in_byte         (in_byte),
        .in_last         (in_last),
        .mode_o          (mode_o),
        .payload_bytes_o (payload_bytes_o),
        .sync_offset_o   (sync_offset_o),
        .done_o          (done_o)
    );

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] be32(input int i);
        return {mem[i], mem[i+1], mem[i+2], mem[i+3]};
    endfunction

    function automatic logic [15:0] be16(input int i);
        return {mem[i], mem[i+1]};
    endfunction

    function automatic int ref_sync(input bit wide, input int len);
        int ws = wide ? 4 : 2;
        for (int k = 0; k + ws <= len; k++) begin
            if (wide && be32(k) == 32'hAA995566) return k;
            if (!wide && be16(k) == 16'hAA99) return k;
        end
        return -1;
    endfunction

    function automatic logic [31:0] ref_count(input bit wide, input int len, input int off);
        logic [31:0] w, n;
        logic [15:0] h;
        if (wide) begin
            for (int i = off + 4; i + 4 <= len; i += 4) begin
                w = be32(i);
                if (w[31:29] == 3'd1 && w[28:27] == 2'd2 && w[17:13] == 5'd2) begin
                    if (w[10:0] != 11'd0) return {21'd0, w[10:0]};
                    if (i + 8 <= len) begin
                        n = be32(i + 4);
                        if (n[31:29] == 3'd2) return {5'd0, n[26:0]};
                    end
                end
            end
        end else begin
            for (int i = off + 2; i + 2 <= len; i += 2) begin
                h = be16(i);
                if (h[15:13] == 3'd2) begin
                    if (i + 6 <= len) return be32(i + 2);
                    return 32'd0;
                end
            end
        end
        return 32'd0;
    endfunction

    function automatic logic [31:0] ref_bytes(input bit wide, input int len);
        int off = ref_sync(wide, len);
        logic [31:0] c;
        if (off < 0) return 32'd0;
        c = ref_count(wide, len, off);
        return wide ? (c << 2) : (c << 1);
    endfunction

    function automatic logic [31:0] hdr32(input logic [2:0] ty, input logic [1:0] op,
                                          input logic [4:0] rg, input logic [10:0] cnt);
        return {ty, op, 9'd0, rg, 2'd0, cnt};
    endfunction

    task automatic put32(input int i, input logic [31:0] v);
        mem[i] = v[31:24]; mem[i+1] = v[23:16]; mem[i+2] = v[15:8]; mem[i+3] = v[7:0];
    endtask

    task automatic put16(input int i, input logic [15:0] v);
        mem[i] = v[15:8]; mem[i+1] = v[7:0];
    endtask

    task automatic zero_mem();
        for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    endtask

    task automatic run_stream(input bit wide, input int len, input logic [31:0] full,
                              input bit gaps, input string req);
        int off;
        logic [31:0] eb;
        logic [1:0]  em;
        logic [15:0] eo;
        @(negedge clk);
        family_wide     = wide;
        full_size_bytes = full;
        for (int i = 0; i < len; i++) begin
            if (i == len / 2) begin
                chk("R11", "held mode", {30'd0, mode_o}, {30'd0, prev_mode});
                chk("R11", "held payload", payload_bytes_o, prev_bytes);
            end
            if (gaps && ($urandom % 4 == 0)) begin
                in_valid = 1'b0; in_last = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_byte  = mem[i];
            in_last  = (i == len - 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        in_last  = 1'b0;
        off = ref_sync(wide, len);
        eb  = ref_bytes(wide, len);
        if (off < 0) begin
            em = 2'd0; eo = 16'd0;
        end else begin
            eo = 16'(off);
            em = (eb == 32'd0 || eb == full) ? 2'd1 : 2'd2;
        end
        chk("R11", "done strobe", {31'd0, done_o}, 32'd1);
        chk(req, "mode", {30'd0, mode_o}, {30'd0, em});
        chk(req, "payload", payload_bytes_o, eb);
        chk(req, "offset", {16'd0, sync_offset_o}, {16'd0, eo});
        prev_mode = em; prev_bytes = eb; prev_off = eo;
        @(negedge clk);
        chk("R11", "done single", {31'd0, done_o}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R11 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int len, s, p, kind;
        bit wide;
        logic [31:0] full;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_byte = 8'h00;
        family_wide = 1'b1; full_size_bytes = 32'd0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset mode", {30'd0, mode_o}, 32'd0);
        chk("R8", "reset payload", payload_bytes_o, 32'd0);
        chk("R8", "reset offset", {16'd0, sync_offset_o}, 32'd0);
        chk("R11", "reset done", {31'd0, done_o}, 32'd0);

        // R1 R4: wide sync at 5, frame header count 100 -> 400 bytes, full
        zero_mem(); put32(5, 32'hAA995566); put32(9, hdr32(3'd1, 2'd2, 5'd2, 11'd100));
        run_stream(1'b1, 20, 32'd400, 1'b0, "R4");
        chk("R10", "full equal", {30'd0, mode_o}, 32'd1);
        // R10: same stream, different full size -> partial
        run_stream(1'b1, 20, 32'd1000, 1'b1, "R10");
        chk("R10", "partial", {30'd0, mode_o}, 32'd2);
        // R5: zero count then type-2 count 5000
        zero_mem(); put32(0, 32'hAA995566); put32(4, hdr32(3'd1, 2'd2, 5'd2, 11'd0));
        put32(8, {3'd2, 2'd0, 27'd5000});
        run_stream(1'b1, 16, 32'd0, 1'b0, "R5");
        chk("R5", "t2 bytes", payload_bytes_o, 32'd20000);
        // R6: zero count then another frame header with count 7
        zero_mem(); put32(4, 32'hAA995566); put32(8, hdr32(3'd1, 2'd2, 5'd2, 11'd0));
        put32(12, hdr32(3'd1, 2'd2, 5'd2, 11'd7));
        run_stream(1'b1, 24, 32'd0, 1'b1, "R6");
        chk("R6", "re-examined", payload_bytes_o, 32'd28);
        // R3: header off alignment is not recognised
        zero_mem(); put32(3, 32'hAA995566); put32(8, hdr32(3'd1, 2'd2, 5'd2, 11'd100));
        run_stream(1'b1, 24, 32'd0, 1'b0, "R3");
        chk("R3", "misaligned", payload_bytes_o, 32'd0);
        // R2 R7: narrow sync at 6, 16-bit type-2, count 0x12345
        zero_mem(); put16(6, 16'hAA99); put16(8, 16'h4000); put32(10, 32'h00012345);
        run_stream(1'b0, 18, 32'h2468A, 1'b1, "R7");
        chk("R2", "narrow offset", {16'd0, sync_offset_o}, 32'd6);
        chk("R7", "narrow bytes", payload_bytes_o, 32'h2468A);
        // R2: two sync bytes are not enough for the wide family
        zero_mem(); put16(2, 16'hAA99);
        run_stream(1'b1, 12, 32'd0, 1'b0, "R2");
        chk("R2", "wide short sync", {30'd0, mode_o}, 32'd0);
        // R8: no sync at all
        zero_mem();
        run_stream(1'b0, 10, 32'd0, 1'b0, "R8");
        chk("R8", "no sync", {30'd0, mode_o}, 32'd0);
        // R12: two headers, first one counts
        zero_mem(); put32(0, 32'hAA995566); put32(4, hdr32(3'd1, 2'd2, 5'd2, 11'd10));
        put32(8, hdr32(3'd1, 2'd2, 5'd2, 11'd20));
        run_stream(1'b1, 16, 32'd0, 1'b0, "R12");
        chk("R12", "first header", payload_bytes_o, 32'd40);
        // R9: narrow header with truncated count
        zero_mem(); put16(0, 16'hAA99); put16(2, 16'h4000); mem[4] = 8'h12; mem[5] = 8'h34;
        run_stream(1'b0, 6, 32'd0, 1'b0, "R9");
        chk("R9", "no length", {30'd0, mode_o}, 32'd1);

        for (int it = 0; it < 300; it++) begin
            wide = 1'($urandom % 2);
            len  = 8 + int'($urandom % 90);
            for (int i = 0; i < 256; i++) mem[i] = 8'($urandom);
            if ($urandom % 4 != 0) begin
                s = int'($urandom % (len / 2));
                put32(s, 32'hAA995566);
                p = s + (wide ? 4 : 2) + (wide ? 4 : 2) * int'($urandom % 4);
                kind = int'($urandom % 3);
                if (p + 8 <= len) begin
                    if (!wide) begin
                        put16(p, {3'd2, 13'($urandom)});
                        put32(p + 2, $urandom);
                    end else if (kind == 0) begin
                        put32(p, hdr32(3'd1, 2'd2, 5'd2, 11'($urandom)));
                    end else begin
                        put32(p, hdr32(3'd1, 2'd2, 5'd2, 11'd0));
                        if (kind == 1) put32(p + 4, {3'd2, 29'($urandom)});
                    end
                end
            end
            full = ($urandom % 3 == 0) ? ref_bytes(wide, len) : $urandom;
            run_stream(wide, len, full, 1'b1, "R10");
        end

        summary();
        $finish;
    end

endmodule